// File: doc/BRIEF.md
# Two-Way Write-Through Cache

This block sits between a processor load/store port and a slower word-addressed memory. Lines are grouped into sets of two. The cache compares both stored tags of the selected set at once. Read hits are answered from local storage. A read miss pulls one whole line from memory in a single wide transfer, places it in the set and returns the requested word.

Writes always go to memory, one word at a time. When the written word is resident, the cached copy is also updated, but only once memory has accepted the word. A write that misses leaves the cache untouched. Memory therefore always holds current data, and no line ever needs to be copied back.

Each set keeps one recency bit that names the way to replace next. An empty way is always filled before an occupied one. The processor holds its request until `cpu_ready` pulses for one cycle.

Top module: `wt_cache2w`

## Requirements
- R1: After reset every line is invalid, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low, and the first read of any address is a miss.
- R2: A read miss raises `mem_rd_req` with `mem_rd_addr` equal to the word address shifted right by the offset width. The offset is the low 2 bits of the word address; the set index is the next 3 bits; the tag is the remaining upper bits. In the cycle `mem_rd_valid` is seen, word `k` of the line is taken from `mem_rd_data[k*DATA_W +: DATA_W]` and the requested word is returned on `cpu_rdata` with `cpu_ready` one cycle later.
- R3: A read hit raises `cpu_ready` in the cycle after the request is first seen, with the cached word and no memory request.
- R4: Two lines with the same set index and different tags can be resident together, and both hit.
- R5: A write hit sends the word to memory and updates the cached word, so a later read returns the new data without a refill.
- R6: A write miss sends only the word to memory, and a later read of that address misses.
- R7: A refill uses an invalid way of the set when one exists, checking way 0 first.
- R8: With both ways valid, a refill evicts the way not used most recently; every hit or fill marks the used way as most recent.
- R9: `mem_wr_req` stays high with stable `mem_wr_addr` and `mem_wr_data` until `mem_wr_ack`, and `cpu_ready` follows the acknowledge by one cycle.
- R10: `cpu_ready` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_rd_req | output | 1 | Line read request |
| mem_rd_addr | output | ADDR_W-OFF_W | Line address |
| mem_rd_valid | input | 1 | Line data present |
| mem_rd_data | input | DATA_W*LINE_WORDS | Whole line, word 0 in the low bits |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_addr | output | ADDR_W | Word address to write |
| mem_wr_data | output | DATA_W | Word to write |
| mem_wr_ack | input | 1 | Memory accepted the word |

## Verification
The hardest case to reach from the ports is a refill into a set whose two ways are both valid, after the recency bit has been moved by hits. The bench first fills both ways of one set with two cold misses. It then reads both lines back in a chosen order to set the recency bit, and brings in a third tag. It then infers which line was evicted from which of the two old lines still hits and which one needs a refill.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2,
      ST_RESP  = 2'd3
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int SETS  = 8,
   parameter int TAG_W = 5,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             fill_en,
   input  logic             fill_way,
   input  logic             touch_en,
   input  logic             touch_way,
   output logic             hit,
   output logic             hit_way,
   output logic             victim_way
);
   logic [SETS-1:0][1:0] valid_q;
   logic [SETS-1:0]      lru_q;
   logic [TAG_W-1:0]     tag_q [SETS][2];
   logic [1:0]           hit_vec;

   for (genvar w = 0; w < 2; w++) begin : g_cmp
      assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
   end

   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];

   always_comb begin
      if (!valid_q[lk_set][0])      victim_way = 1'b0;
      else if (!valid_q[lk_set][1]) victim_way = 1'b1;
      else                          victim_way = lru_q[lk_set];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         lru_q   <= '0;
      end else if (fill_en) begin
         valid_q[lk_set][fill_way] <= 1'b1;
         lru_q[lk_set]             <= ~fill_way;
      end else if (touch_en) begin
         lru_q[lk_set] <= ~touch_way;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[lk_set][fill_way] <= lk_tag;
   end

   // R4: one set never holds the same tag twice
   assert_hit_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R7: an empty way is filled first
   assert_fill_empty0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en && !valid_q[lk_set][0] |-> fill_way == 1'b0);
   assert_fill_empty1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en && valid_q[lk_set][0] && !valid_q[lk_set][1] |-> fill_way == 1'b1);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int SETS       = 8,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32,
   localparam int SET_W = $clog2(SETS),
   localparam int OFF_W = $clog2(LINE_WORDS)
) (
   input  logic                         clk,
   input  logic [SET_W-1:0]             set_idx,
   input  logic [OFF_W-1:0]             word_off,
   input  logic                         rd_way,
   input  logic                         fill_en,
   input  logic                         fill_way,
   input  logic [DATA_W*LINE_WORDS-1:0] fill_line,
   input  logic                         wr_en,
   input  logic                         wr_way,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [DATA_W-1:0]            rd_word
);
   logic [DATA_W-1:0] word_q [SETS][2][LINE_WORDS];

   assign rd_word = word_q[set_idx][rd_way][word_off];

   for (genvar k = 0; k < LINE_WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (fill_en)
            word_q[set_idx][fill_way][k] <= fill_line[k*DATA_W +: DATA_W];
         else if (wr_en && word_off == OFF_W'(k))
            word_q[set_idx][wr_way][k] <= wr_data;
      end
   end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              hit,
   input  logic              hit_way,
   input  logic              victim_way,
   input  logic [DATA_W-1:0] cache_word,
   input  logic [DATA_W-1:0] fill_word,
   input  logic              mem_rd_valid,
   input  logic              mem_wr_ack,
   output logic              idle,
   output logic [ADDR_W-1:0] addr_q,
   output logic              way_q,
   output logic              fill_en,
   output logic              touch_en,
   output logic              touch_way,
   output logic              data_wr_en,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-OFF_W-1:0] mem_rd_addr,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);
   wtc_state_e        state;
   logic              hit_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rd_hit_now;

   assign idle       = (state == ST_IDLE);
   assign rd_hit_now = idle && cpu_req && !cpu_we && hit;
   assign fill_en    = (state == ST_FILL) && mem_rd_valid;
   assign data_wr_en = (state == ST_WRITE) && mem_wr_ack && hit_q;
   assign touch_en   = rd_hit_now || data_wr_en;
   assign touch_way  = idle ? hit_way : way_q;

   assign cpu_ready   = (state == ST_RESP);
   assign cpu_rdata   = rdata_q;
   assign mem_rd_req  = (state == ST_FILL);
   assign mem_rd_addr = addr_q[ADDR_W-1:OFF_W];
   assign mem_wr_req  = (state == ST_WRITE);
   assign mem_wr_addr = addr_q;
   assign mem_wr_data = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         way_q   <= 1'b0;
         hit_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (cpu_req) begin
               addr_q  <= cpu_addr;
               wdata_q <= cpu_wdata;
               if (cpu_we) begin
                  way_q <= hit_way;
                  hit_q <= hit;
                  state <= ST_WRITE;
               end else if (hit) begin
                  rdata_q <= cache_word;
                  state   <= ST_RESP;
               end else begin
                  way_q <= victim_way;
                  state <= ST_FILL;
               end
            end
            ST_FILL: if (mem_rd_valid) begin
               rdata_q <= fill_word;
               state   <= ST_RESP;
            end
            ST_WRITE: if (mem_wr_ack) state <= ST_RESP;
            ST_RESP:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // R3: a read hit answers next cycle without touching memory
   assert_rd_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit_now |=> cpu_ready && !mem_rd_req && !mem_wr_req);
   // R9: write request held steady until acknowledged
   assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));
   assert_wr_ack_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req && mem_wr_ack |=> cpu_ready);
   // R10: ready is a single pulse
   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/wt_cache2w.sv
module wt_cache2w #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int SETS       = 8,
   parameter int LINE_WORDS = 4,
   localparam int OFF_W = $clog2(LINE_WORDS),
   localparam int SET_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cpu_req,
   input  logic                         cpu_we,
   input  logic [ADDR_W-1:0]            cpu_addr,
   input  logic [DATA_W-1:0]            cpu_wdata,
   output logic                         cpu_ready,
   output logic [DATA_W-1:0]            cpu_rdata,
   output logic                         mem_rd_req,
   output logic [ADDR_W-OFF_W-1:0]      mem_rd_addr,
   input  logic                         mem_rd_valid,
   input  logic [DATA_W*LINE_WORDS-1:0] mem_rd_data,
   output logic                         mem_wr_req,
   output logic [ADDR_W-1:0]            mem_wr_addr,
   output logic [DATA_W-1:0]            mem_wr_data,
   input  logic                         mem_wr_ack
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   logic              idle, way_q, fill_en, touch_en, touch_way, data_wr_en;
   logic              hit, hit_way, victim_way;
   logic [ADDR_W-1:0] addr_q, lk_addr;
   logic [DATA_W-1:0] cache_word, fill_word;

   assign lk_addr   = idle ? cpu_addr : addr_q;
   assign fill_word = mem_rd_data[addr_q[OFF_W-1:0]*DATA_W +: DATA_W];

   wtc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_set(lk_addr[OFF_W +: SET_W]), .lk_tag(lk_addr[ADDR_W-1 -: TAG_W]),
      .fill_en(fill_en), .fill_way(way_q),
      .touch_en(touch_en), .touch_way(touch_way),
      .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
   );

   wtc_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) i_data (
      .clk(clk), .set_idx(lk_addr[OFF_W +: SET_W]), .word_off(lk_addr[OFF_W-1:0]),
      .rd_way(hit_way), .fill_en(fill_en), .fill_way(way_q), .fill_line(mem_rd_data),
      .wr_en(data_wr_en), .wr_way(way_q), .wr_data(mem_wr_data), .rd_word(cache_word)
   );

   wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
      .cache_word(cache_word), .fill_word(fill_word),
      .mem_rd_valid(mem_rd_valid), .mem_wr_ack(mem_wr_ack),
      .idle(idle), .addr_q(addr_q), .way_q(way_q), .fill_en(fill_en),
      .touch_en(touch_en), .touch_way(touch_way), .data_wr_en(data_wr_en),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   // R1: nothing is requested from memory while reset is held
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> !mem_rd_req && !mem_wr_req && !cpu_ready);
endmodule

// File: tb/test_wt_cache2w.sv
module test_wt_cache2w;
   localparam int AW = 10, DW = 32, LW = 4, RD_LAT = 2, WR_LAT = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 0, cpu_we = 0, cpu_ready;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
   logic mem_rd_req, mem_rd_valid = 0, mem_wr_req, mem_wr_ack = 0;
   logic [AW-3:0] mem_rd_addr;
   logic [DW*LW-1:0] mem_rd_data = '0;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;

   logic [DW-1:0] mem_arr [1 << AW];
   int fills = 0, writes = 0, rd_wait = 0, wr_wait = 0;
   int checks = 0, fails = 0;
   logic [AW-1:0] last_wa, held_wa;
   logic [DW-1:0] last_wd, held_wd;
   bit wr_unstable = 0;

   always #10 clk = ~clk;

   wt_cache2w i_wt_cache2w (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   // memory responder, driven away from the active edge
   always @(negedge clk) begin
      if (mem_rd_valid) begin
         mem_rd_valid = 0; rd_wait = 0;
      end else if (mem_rd_req) begin
         if (rd_wait == RD_LAT) begin
            for (int k = 0; k < LW; k++)
               mem_rd_data[k*DW +: DW] = mem_arr[{mem_rd_addr, 2'(k)}];
            mem_rd_valid = 1; fills++;
         end else rd_wait++;
      end
      if (mem_wr_ack) begin
         mem_wr_ack = 0; wr_wait = 0;
      end else if (mem_wr_req) begin
         if (wr_wait == 0) begin held_wa = mem_wr_addr; held_wd = mem_wr_data; end
         else if (mem_wr_addr != held_wa || mem_wr_data != held_wd) wr_unstable = 1;
         if (wr_wait == WR_LAT) begin
            mem_arr[mem_wr_addr] = mem_wr_data;
            last_wa = mem_wr_addr; last_wd = mem_wr_data;
            mem_wr_ack = 1; writes++;
         end else wr_wait++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output int cyc);
      cyc = 0;
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      do begin
         @(negedge clk); cyc++;
      end while (!cpu_ready && cyc < 1000);
      rd = cpu_rdata;
      cpu_req = 0;
      @(negedge clk);
      check("R10 ready pulse", 32'(cpu_ready), 32'd0);
   endtask

   task automatic rd_expect(input string req, input logic [AW-1:0] a, input int fill_delta);
      logic [DW-1:0] rd; int cyc; int f0;
      f0 = fills;
      access(0, a, '0, rd, cyc);
      check({req, " data"}, rd, mem_arr[a]);
      check({req, " refill count"}, 32'(fills - f0), 32'(fill_delta));
   endtask

   task automatic t_reset();
      check("R1 ready low", 32'(cpu_ready), 0);
      check("R1 no read req", 32'(mem_rd_req), 0);
      check("R1 no write req", 32'(mem_wr_req), 0);
   endtask

   task automatic t_miss_then_hit();
      logic [DW-1:0] rd; int cyc; int f0;
      rd_expect("R1 R2 cold miss", 10'h023, 1);
      f0 = fills;
      access(0, 10'h021, '0, rd, cyc);
      check("R3 hit data", rd, mem_arr[10'h021]);
      check("R3 hit latency", 32'(cyc), 32'd1);
      check("R3 no refill", 32'(fills - f0), 0);
   endtask

   task automatic t_ways_and_lru();
      rd_expect("R7 fill way0", 10'h004, 1);
      rd_expect("R7 fill empty way1", 10'h024, 1);
      rd_expect("R4 hit second line", 10'h024, 0);
      rd_expect("R4 hit first line", 10'h004, 0);
      rd_expect("R8 third tag", 10'h044, 1);
      rd_expect("R8 recent line kept", 10'h004, 0);
      rd_expect("R8 stale line evicted", 10'h024, 1);
      rd_expect("R8 third tag evicted", 10'h044, 1);
   endtask

   task automatic t_write_hit();
      logic [DW-1:0] rd; int cyc; int w0, f0;
      w0 = writes; f0 = fills;
      access(1, 10'h021, 32'hDEADBEEF, rd, cyc);
      check("R5 one mem write", 32'(writes - w0), 1);
      check("R5 write addr", 32'(last_wa), 32'h021);
      check("R5 write data", last_wd, 32'hDEADBEEF);
      check("R9 ready after ack", 32'(cyc), 32'(WR_LAT + 2));
      check("R9 request stable", 32'(wr_unstable), 0);
      check("R5 no refill on write", 32'(fills - f0), 0);
      rd_expect("R5 read updated word", 10'h021, 0);
   endtask

   task automatic t_write_miss();
      logic [DW-1:0] rd; int cyc; int w0, f0;
      w0 = writes; f0 = fills;
      access(1, 10'h3F0, 32'h0BADF00D, rd, cyc);
      check("R6 one mem write", 32'(writes - w0), 1);
      check("R6 write data", last_wd, 32'h0BADF00D);
      check("R6 no refill", 32'(fills - f0), 0);
      rd_expect("R6 not allocated", 10'h3F0, 1);
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) mem_arr[i] = 32'h5A000000 + i * 32'h00010003;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_miss_then_hit();
      t_ways_and_lru();
      t_write_hit();
      t_write_miss();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule